// File: doc/BRIEF.md
# Pin Interrupt Controller Register Bank

This block is the register front end of a pin interrupt controller with one input per pin. Three control vectors decide how each pin is handled: a mask that enables it toward the interrupt output, an edge-select bit, and a polarity-invert bit. None of the three vectors has a direct address. Each is changed through two aliases: a set alias, where ones in the written data set bits, and a clear alias, where ones in the written data clear bits. A read of either alias returns the shared vector. The block also holds a plain request register and a pin-assignment register. The assignment register's reset value depends on an instance parameter.

Each pin passes through a two-flop synchronizer and is then XORed with its invert bit. The result is the pin's conditioned level, which is copied into a read-only pin-state register every cycle. In edge mode a rising conditioned level sets a sticky latch bit, and software clears it by writing a one. In level mode the latch bit follows the conditioned level. The interrupt output is the registered OR of the latch bits that are enabled by the mask.

Every bus access is a single-cycle request. Read data and the error flag appear one cycle later. An access is rejected if its size is not 32 bits or its address is not a mapped word, and a rejected access changes nothing.

Top module: `pin_irq_regbank`

## Requirements
- R1: After reset, every register reads zero except the assignment register, which reads 0x00000101 for instances 0 and 2, 0x01010000 for instance 1 and 0x02020303 for instance 3.
- R2: Writing to a set alias (mask 0x00, edge 0x10, invert 0x18) sets the vector bits that are one in the data and leaves the other bits alone. A read of either alias returns the vector.
- R3: Writing to a clear alias (mask 0x04, edge 0x14, invert 0x1C) clears the vector bits that are one in the data and leaves the other bits alone.
- R4: The request register (0x08) and the assignment register (0x0C) store a written word and return it on a read.
- R5: An access whose size code is not 2'b10 (32-bit) returns the error flag and zero read data one cycle later, whether the address is mapped or not, and changes no register.
- R6: An access to a misaligned address, or to any word offset from 0x28 upward, returns the error flag and changes no register. Valid accesses return the error flag at zero.
- R7: The pin-state register (0x20) reads the synchronized pin level XOR the invert bit, three clock edges after the pin changes. Writes to it are ignored.
- R8: With its edge bit at 1, a rising conditioned level sets the latch bit (0x24). The bit stays set until a one is written to it. With its edge bit at 0, the latch bit follows the conditioned level, and writes to it have no effect.
- R9: The interrupt output is 1 exactly when some latch bit and its mask bit are both 1, registered one cycle after the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset from the block base |
| bus_size | input | 2 | Access size code, 2'b10 for 32 bits |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid one cycle after the request |
| bus_err | output | 1 | Error response, valid one cycle after the request |
| pins_in | input | W | Asynchronous pin inputs |
| irq | output | 1 | Masked interrupt request |

## Verification
Bus results, read data and the error flag, are due at the first clock edge after the request. The bench drives on the falling edge and samples at the next falling edge. Register writes take effect at that same edge, so the next access already sees them. A pin change reaches pin-state and the latch after three edges, and the interrupt output after four. The bench therefore waits at least five cycles after moving a pin before it reads or samples. It waits two cycles after a mask write before it samples the interrupt output.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int REG_COUNT = 10;
  localparam int IDX_BITS  = 4;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [IDX_BITS-1:0] {
    IDX_MSET   = 4'd0,
    IDX_MCLR   = 4'd1,
    IDX_REQ    = 4'd2,
    IDX_ASGN   = 4'd3,
    IDX_ESET   = 4'd4,
    IDX_ECLR   = 4'd5,
    IDX_ISET   = 4'd6,
    IDX_ICLR   = 4'd7,
    IDX_PSTATE = 4'd8,
    IDX_LATCH  = 4'd9
  } reg_idx_e;

  function automatic logic [31:0] assign_reset(input int inst);
    case (inst)
      0, 2:    assign_reset = 32'h0000_0101;
      1:       assign_reset = 32'h0101_0000;
      3:       assign_reset = 32'h0202_0303;
      default: assign_reset = 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/pint_decode.sv
module pint_decode import pint_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic                 en,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  output logic [REG_COUNT-1:0] wr_sel,
  output logic                 rd_ok,
  output logic [IDX_BITS-1:0]  idx,
  output logic                 err
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] word_idx;
  logic aligned, mapped, size_ok, acc_ok;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign mapped   = aligned && (word_idx < WIDX_W'(REG_COUNT));
  assign size_ok  = (size == SIZE_WORD);
  assign acc_ok   = en && size_ok && mapped;
  // size violation is reported first; either failure gives the same response
  assign err      = en && (!size_ok || !mapped);
  assign rd_ok    = acc_ok && !we;
  assign idx      = mapped ? IDX_BITS'(word_idx) : '0;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_sel
    assign wr_sel[g] = acc_ok && we && (idx == IDX_BITS'(g));
  end
endmodule

// File: rtl/pint_setclr_vec.sv
module pint_setclr_vec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_we) q <= q | wdata;
    else if (clr_we) q <= q & ~wdata;
  end
endmodule

// File: rtl/pint_pin_latch.sv
module pint_pin_latch #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] invert,
  input  logic [W-1:0] edge_mode,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] cond,
  output logic [W-1:0] pstate,
  output logic [W-1:0] latch
);
  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, clr_mask, latch_d;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= pins;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign cond     = sync_q[SYNC_STAGES-1] ^ invert;
  assign rise     = cond & ~prev_q;
  assign clr_mask = clr_we ? clr_data : '0;
  // edge bits: sticky, new rise beats a same-cycle clear; level bits: follow
  assign latch_d  = (edge_mode & ((latch & ~clr_mask) | rise)) | (~edge_mode & cond);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pstate <= '0;
      latch  <= '0;
    end else begin
      prev_q <= cond;
      pstate <= cond;
      latch  <= latch_d;
    end
  end
endmodule

// File: rtl/pin_irq_regbank.sv
module pin_irq_regbank import pint_pkg::*; #(
  parameter int ADDR_W   = 6,
  parameter int W        = 32,
  parameter int INSTANCE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_err,
  input  logic [W-1:0]      pins_in,
  output logic              irq
);
  localparam logic [W-1:0] ASGN_RST = W'(assign_reset(INSTANCE));

  logic [REG_COUNT-1:0] wr_sel;
  logic                 rd_ok, dec_err;
  logic [IDX_BITS-1:0]  idx;
  logic [W-1:0] mask_q, edge_q, inv_q, req_q, asgn_q;
  logic [W-1:0] cond, pstate_q, latch_q, rd_mux;

  pint_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en(bus_en), .we(bus_we), .addr(bus_addr), .size(bus_size),
    .wr_sel(wr_sel), .rd_ok(rd_ok), .idx(idx), .err(dec_err)
  );

  pint_setclr_vec #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .set_we(wr_sel[IDX_MSET]), .clr_we(wr_sel[IDX_MCLR]),
    .wdata(bus_wdata), .q(mask_q)
  );
  pint_setclr_vec #(.W(W)) u_edge (
    .clk(clk), .rst(rst), .set_we(wr_sel[IDX_ESET]), .clr_we(wr_sel[IDX_ECLR]),
    .wdata(bus_wdata), .q(edge_q)
  );
  pint_setclr_vec #(.W(W)) u_inv (
    .clk(clk), .rst(rst), .set_we(wr_sel[IDX_ISET]), .clr_we(wr_sel[IDX_ICLR]),
    .wdata(bus_wdata), .q(inv_q)
  );

  pint_pin_latch #(.W(W), .SYNC_STAGES(2)) u_pins (
    .clk(clk), .rst(rst), .pins(pins_in), .invert(inv_q), .edge_mode(edge_q),
    .clr_we(wr_sel[IDX_LATCH]), .clr_data(bus_wdata),
    .cond(cond), .pstate(pstate_q), .latch(latch_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      asgn_q <= ASGN_RST;
    end else begin
      if (wr_sel[IDX_REQ])  req_q  <= bus_wdata;
      if (wr_sel[IDX_ASGN]) asgn_q <= bus_wdata;
    end
  end

  always_comb begin
    case (idx)
      IDX_MSET, IDX_MCLR: rd_mux = mask_q;
      IDX_ESET, IDX_ECLR: rd_mux = edge_q;
      IDX_ISET, IDX_ICLR: rd_mux = inv_q;
      IDX_REQ:            rd_mux = req_q;
      IDX_ASGN:           rd_mux = asgn_q;
      IDX_PSTATE:         rd_mux = pstate_q;
      IDX_LATCH:          rd_mux = latch_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_ok ? rd_mux : '0;
      bus_err   <= dec_err;
      irq       <= |(latch_q & mask_q);
    end
  end
endmodule

// File: rtl/pint_regbank_chk.sv
module pint_regbank_chk #(
  parameter int ADDR_W = 6,
  parameter int W      = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              bus_err,
  input logic              irq,
  input logic [W-1:0]      mask_q,
  input logic [W-1:0]      req_q,
  input logic [W-1:0]      latch_q,
  input logic [W-1:0]      pstate_q,
  input logic [W-1:0]      cond
);
  logic good_wr;
  assign good_wr = bus_en && bus_we && (bus_size == 2'b10) && (bus_addr[1:0] == 2'b00);

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (rst)
    good_wr && bus_addr == ADDR_W'(8'h00) |=> (mask_q & $past(bus_wdata)) == $past(bus_wdata));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (rst)
    good_wr && bus_addr == ADDR_W'(8'h04) |=> (mask_q & $past(bus_wdata)) == '0);

  assert_size_err_R5: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_size != 2'b10 |=> bus_err && bus_rdata == '0);

  assert_size_keeps_req_R5: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_size != 2'b10 |=> $stable(req_q));

  assert_unmapped_err_R6: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_addr[1:0] != 2'b00 |=> bus_err);

  assert_pstate_track_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pstate_q == $past(cond));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(|(latch_q & mask_q)));
endmodule

bind pin_irq_regbank pint_regbank_chk #(.ADDR_W(ADDR_W), .W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .irq(irq), .mask_q(mask_q), .req_q(req_q),
  .latch_q(latch_q), .pstate_q(pstate_q), .cond(cond)
);

// File: tb/pin_irq_regbank_bench.sv
module pin_irq_regbank_bench;
  localparam int AW = 6;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_size = 2'b10;
  logic [W-1:0]  bus_wdata = '0, pins_in = '0;
  logic [W-1:0]  bus_rdata;
  logic          bus_err, irq;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_mask, m_edge, m_inv, m_req, m_asgn;

  always #2 clk = ~clk;

  pin_irq_regbank #(.ADDR_W(AW), .W(W), .INSTANCE(3)) u_pin_irq_regbank (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pins_in(pins_in), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [W-1:0] d, output logic [W-1:0] rd, output logic er);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pins_in = '0;
    cycles(3); rst = 1'b0;
    m_mask = '0; m_edge = '0; m_inv = '0; m_req = '0; m_asgn = 32'h0202_0303;
  endtask

  function automatic logic [W-1:0] model_read(input int idx);
    case (idx)
      0, 1: model_read = m_mask;
      2:    model_read = m_req;
      3:    model_read = m_asgn;
      4, 5: model_read = m_edge;
      6, 7: model_read = m_inv;
      default: model_read = '0;
    endcase
  endfunction

  task automatic model_write(input int idx, input logic [W-1:0] d);
    case (idx)
      0: m_mask |= d;   1: m_mask &= ~d;
      2: m_req = d;     3: m_asgn = d;
      4: m_edge |= d;   5: m_edge &= ~d;
      6: m_inv |= d;    7: m_inv &= ~d;
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    logic er;
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R1 reset values
    for (int i = 0; i < 10; i++) begin
      access(1'b0, AW'(i * 4), 2'b10, '0, rd, er);
      check($sformatf("R1 reset reg %0d", i), rd, (i == 3) ? 32'h0202_0303 : 32'h0);
    end
    check("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 R3 directed alias checks
    access(1'b1, 6'h00, 2'b10, 32'hF0F0_0001, rd, er);
    access(1'b0, 6'h04, 2'b10, 0, rd, er);
    check("R2 set via clear alias read", rd, 32'hF0F0_0001);
    access(1'b1, 6'h04, 2'b10, 32'h3000_0001, rd, er);
    access(1'b0, 6'h00, 2'b10, 0, rd, er);
    check("R3 clear alias", rd, 32'hC0F0_0000);
    check("R6 no err on valid", {31'b0, er}, 32'h0);
    m_mask = 32'hC0F0_0000;

    // R2 R3 R4 random traffic against model
    for (int n = 0; n < 300; n++) begin
      int idx;
      logic [W-1:0] d;
      idx = int'($urandom % 8);
      d = $urandom;
      if ($urandom % 2 == 0) begin
        access(1'b1, AW'(idx * 4), 2'b10, d, rd, er);
        model_write(idx, d);
      end else begin
        access(1'b0, AW'(idx * 4), 2'b10, 0, rd, er);
        check((idx == 2 || idx == 3) ? "R4 plain reg read" :
              ((idx % 2 == 0) ? "R2 alias read" : "R3 alias read"), rd, model_read(idx));
      end
    end

    // R5 size errors
    access(1'b1, 6'h08, 2'b01, 32'hDEAD_BEEF, rd, er);
    check("R5 size err flag", {31'b0, er}, 32'h1);
    access(1'b0, 6'h08, 2'b00, 0, rd, er);
    check("R5 size err read data", rd, 32'h0);
    check("R5 size err flag read", {31'b0, er}, 32'h1);
    access(1'b1, 6'h30, 2'b11, 32'h1, rd, er);
    check("R5 size err on unmapped", {31'b0, er}, 32'h1);
    access(1'b0, 6'h08, 2'b10, 0, rd, er);
    check("R5 request unchanged", rd, m_req);

    // R6 unmapped and misaligned
    access(1'b1, 6'h28, 2'b10, 32'hFFFF_FFFF, rd, er);
    check("R6 unmapped err", {31'b0, er}, 32'h1);
    access(1'b1, 6'h09, 2'b10, 32'h1234_5678, rd, er);
    check("R6 misaligned err", {31'b0, er}, 32'h1);
    access(1'b0, 6'h08, 2'b10, 0, rd, er);
    check("R6 request unchanged", rd, m_req);

    // Pin behaviour from a clean state
    do_reset();
    pins_in = 32'h0000_00F0;
    cycles(5);
    access(1'b0, 6'h20, 2'b10, 0, rd, er);
    check("R7 pin-state level", rd, 32'h0000_00F0);
    access(1'b0, 6'h24, 2'b10, 0, rd, er);
    check("R8 level latch follows", rd, 32'h0000_00F0);
    access(1'b1, 6'h20, 2'b10, 32'hFFFF_0000, rd, er);
    access(1'b0, 6'h20, 2'b10, 0, rd, er);
    check("R7 pin-state write ignored", rd, 32'h0000_00F0);
    check("R9 irq off while masked", {31'b0, irq}, 32'h0);
    access(1'b1, 6'h00, 2'b10, 32'h0000_0010, rd, er);
    cycles(2);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    access(1'b1, 6'h24, 2'b10, 32'h0000_0010, rd, er);
    access(1'b0, 6'h24, 2'b10, 0, rd, er);
    check("R8 level latch write no effect", rd, 32'h0000_00F0);
    pins_in = 32'h0;
    cycles(5);
    check("R9 irq off after level drop", {31'b0, irq}, 32'h0);

    // R8 edge mode on bits 15:8
    access(1'b1, 6'h10, 2'b10, 32'h0000_FF00, rd, er);
    access(1'b1, 6'h00, 2'b10, 32'h0000_0200, rd, er);
    pins_in = 32'h0000_0200;
    cycles(4);
    pins_in = 32'h0;
    cycles(5);
    access(1'b0, 6'h24, 2'b10, 0, rd, er);
    check("R8 edge latch sticky", rd, 32'h0000_0200);
    check("R9 irq from edge", {31'b0, irq}, 32'h1);
    access(1'b1, 6'h24, 2'b10, 32'h0000_0200, rd, er);
    access(1'b0, 6'h24, 2'b10, 0, rd, er);
    check("R8 edge latch cleared", rd, 32'h0);
    cycles(1);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);

    // R7 invert
    access(1'b1, 6'h18, 2'b10, 32'h0000_0001, rd, er);
    cycles(5);
    access(1'b0, 6'h20, 2'b10, 0, rd, er);
    check("R7 inverted pin-state", rd, 32'h0000_0001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule